// File: doc/BRIEF.md
# Burst Shift Port

The block moves bits in and out over one clock line, one data-out line and one data-in line. The serial clock idles high. Each bit is driven onto the data-out line when the clock falls. The data-in line is sampled when the clock rises. The clock can come from an internal 8-bit divider (master) or from a pin (slave); in slave mode the pin is passed through a two-stage synchronizer before edge detection.

There are two kinds of transfer:
- A single transfer shifts exactly one byte through the shift register.
- A continuous transfer streams any number of bits from 1 to 256 through a 32-byte local buffer. At every byte boundary the received byte goes back into the buffer slot it came from, and the next slot is loaded for sending.

A continuous transfer can be held at a byte boundary and later resumed. On completion the block raises a sticky done bit and a one-cycle interrupt pulse.

Software uses a byte-wide register port, and reads are combinational:
- Address 0x00 is control: bit0 run, bit1 master, bit2 MSB first, bit3 continuous, bit4 hold, bit5 done.
- Address 0x01 holds the divider.
- Address 0x02 holds the length minus one.
- Address 0x03 is the shift register.
- Addresses 0x20 to 0x3F are the buffer.

Top module: `burst_shift_port`

## Requirements
- R1: After reset the clock output and data output are high, the clock enable output and interrupt are low, and control (0x00) reads 0.
- R2: In master mode with divider value D (0x01, 0 allowed), the clock period is 2*(D+1) cycles, and the clock is high whenever no bit is in progress.
- R3: Each data-out bit changes only on a falling serial clock edge, and each data-in bit is taken on a rising edge.
- R4: Control bit2 = 1 sends and fills each byte starting at bit 7; bit2 = 0 starts at bit 0.
- R5: With control bit3 = 0, a start (bit0 = 1) shifts the 8 bits of register 0x03, and the received byte then reads back from 0x03.
- R6: With control bit3 = 1, a start sends L+1 bits (L from 0x02). Bit i comes from buffer byte i/8, and each received byte is written to the buffer byte it was sent from.
- R7: When the length is not a multiple of 8, the final received byte is stored right-aligned in the selected order. Its first received bit goes to bit k-1 in MSB order or to bit 0 in LSB order (k bits, k < 8), and its unused upper bits are zero.
- R8: While control bit4 is set, a continuous transfer stops after a byte that is not its last, with the clock held high. Clearing bit4 resumes the stream with the next byte.
- R9: Control bit0 reads 1 while busy and clears at completion. At completion, bit5 sets and the interrupt pulses for exactly one cycle.
- R10: Control bit1 = 1 drives the clock line (enable output high); bit1 = 0 takes edges from the clock input pin (enable output low).
- R11: While busy, writes to 0x01, 0x02, 0x03 and the buffer are ignored, and a control write changes only bit4.
- R12: Buffer bytes beyond the transferred length, and the whole buffer in single mode, keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register or buffer address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for regAddr |
| sckIn | input | 1 | Serial clock from pin (slave mode) |
| sckOut | output | 1 | Serial clock to pin (master mode) |
| sckOe | output | 1 | Serial clock drive enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach is the hold between bytes of a live continuous transfer. The hold bit is therefore set in the same control write that starts the stream, so the engine parks after exactly eight bits. While the engine is parked, the bench tries writes to every configuration register and to the buffer. It then checks the partial results and the ignored writes through the register port, and only after that releases the hold. Partial final bytes are reached by sweeping every length from 1 to 40 and from 249 to 256 in both bit orders.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic loadFirst;
    logic loadNext;
    logic driveOut;
    logic shiftIn;
    logic storeByte;
  } bspStb_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} bspState_e;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_BAUD  = 2'd1;
  localparam logic [1:0] SEL_LEN   = 2'd2;
  localparam logic [1:0] SEL_SHIFT = 2'd3;

  localparam int B_RUN    = 0;
  localparam int B_MASTER = 1;
  localparam int B_MSB    = 2;
  localparam int B_CONT   = 3;
  localparam int B_HOLD   = 4;
endpackage

// File: rtl/bsp_clkgen.sv
module bsp_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             master,
  input  logic [DIV_W-1:0] div,
  input  logic             sckIn,
  output logic             sckOut,
  output logic             fallStb,
  output logic             riseStb
);
  logic [DIV_W-1:0] cnt;
  logic [2:0]       syncQ;
  logic             tick;

  assign tick = en && master && (cnt == div);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      sckOut <= 1'b1;
    end else if (!en || !master) begin
      cnt    <= '0;
      sckOut <= 1'b1;
    end else if (tick) begin
      cnt    <= '0;
      sckOut <= ~sckOut;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 3'b111;
    else       syncQ <= {syncQ[1:0], sckIn};
  end

  always_comb begin
    if (master) begin
      fallStb = tick && sckOut;
      riseStb = tick && !sckOut;
    end else begin
      fallStb = en && syncQ[2] && !syncQ[1];
      riseStb = en && !syncQ[2] && syncQ[1];
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> sckOut);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && master) |-> (cnt <= div));
endmodule

// File: rtl/bsp_ctrl.sv
module bsp_ctrl
  import bsp_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int DIV_W     = 8,
  localparam int PTR_W    = $clog2(BUF_BYTES),
  localparam int LEN_W    = $clog2(BUF_BYTES * 8)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCtrl,
  input  logic             wrBaud,
  input  logic             wrLen,
  input  logic [7:0]       regWdata,
  input  logic             fallStb,
  input  logic             riseStb,
  output bspStb_t          stb,
  output logic [PTR_W-1:0] ptr,
  output logic [2:0]       partTop,
  output logic             busy,
  output logic             clkEn,
  output logic             master,
  output logic             msbFirst,
  output logic [DIV_W-1:0] divRd,
  output logic [LEN_W-1:0] lenRd,
  output logic [7:0]       ctrlRd,
  output logic             irq
);
  bspState_e        state;
  logic             contQ, holdQ, doneQ;
  logic [LEN_W-1:0] lenQ, bitIdx, lastIdx;
  logic             lastBit, byteEnd, startReq;

  assign busy     = (state != ST_IDLE);
  assign clkEn    = (state == ST_RUN);
  assign lastIdx  = contQ ? lenQ : LEN_W'(7);
  assign lastBit  = (bitIdx == lastIdx);
  assign byteEnd  = (bitIdx[2:0] == 3'd7) || lastBit;
  assign startReq = wrCtrl && !busy && regWdata[B_RUN];
  assign partTop  = lastBit ? lastIdx[2:0] : 3'd7;
  assign lenRd    = lenQ;
  assign ctrlRd   = {2'b00, doneQ, holdQ, contQ, msbFirst, master, busy};

  always_comb begin
    stb           = '0;
    stb.loadFirst = startReq && regWdata[B_CONT];
    if (state == ST_RUN) begin
      stb.driveOut  = fallStb;
      stb.shiftIn   = riseStb;
      stb.storeByte = riseStb && contQ && byteEnd;
      stb.loadNext  = riseStb && contQ && byteEnd && !lastBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      master   <= 1'b0;
      msbFirst <= 1'b0;
      contQ    <= 1'b0;
      holdQ    <= 1'b0;
      doneQ    <= 1'b0;
      irq      <= 1'b0;
      divRd    <= '0;
      lenQ     <= '0;
      bitIdx   <= '0;
      ptr      <= '0;
    end else begin
      irq <= 1'b0;
      if (wrBaud && !busy) divRd <= regWdata[DIV_W-1:0];
      if (wrLen && !busy)  lenQ  <= regWdata[LEN_W-1:0];
      if (wrCtrl) begin
        holdQ <= regWdata[B_HOLD];
        if (!busy) begin
          master   <= regWdata[B_MASTER];
          msbFirst <= regWdata[B_MSB];
          contQ    <= regWdata[B_CONT];
        end
      end
      if (startReq) begin
        state  <= ST_RUN;
        bitIdx <= '0;
        ptr    <= '0;
        doneQ  <= 1'b0;
      end
      case (state)
        ST_RUN: begin
          if (riseStb) begin
            if (lastBit) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
              irq   <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
              if (contQ && byteEnd) begin
                ptr <= ptr + 1'b1;
                if (holdQ) state <= ST_HOLD;
              end
            end
          end
        end
        ST_HOLD: if (!holdQ) state <= ST_RUN;
        default: ;
      endcase
    end
  end

  // R9
  irq_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!busy && doneQ));
  // R8
  hold_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> (bitIdx[2:0] == 3'd0));
  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitIdx <= lastIdx));
  // R11
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lenQ));
endmodule

// File: rtl/bsp_datapath.sv
module bsp_datapath
  import bsp_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  localparam int PTR_W    = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  bspStb_t          stb,
  input  logic [PTR_W-1:0] ptr,
  input  logic [2:0]       partTop,
  input  logic             msbFirst,
  input  logic             busy,
  input  logic             sdi,
  input  logic             wrShift,
  input  logic             wrBuf,
  input  logic [PTR_W-1:0] bufIdx,
  input  logic [7:0]       regWdata,
  output logic             sdo,
  output logic [7:0]       shRd,
  output logic [7:0]       bufRd
);
  logic [7:0] mem [BUF_BYTES];
  logic [7:0] sh, shNext, aligned;

  assign shNext  = msbFirst ? {sh[6:0], sdi} : {sdi, sh[7:1]};
  assign aligned = msbFirst ? (shNext & (8'hFF >> (3'd7 - partTop)))
                            : (shNext >> (3'd7 - partTop));
  assign shRd    = sh;
  assign bufRd   = mem[bufIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= '0;
    end else if (stb.storeByte) begin
      mem[ptr] <= aligned;
    end else if (wrBuf && !busy) begin
      mem[bufIdx] <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sh <= '0;
    else if (stb.loadFirst)     sh <= mem[0];
    else if (stb.loadNext)      sh <= mem[ptr + 1'b1];
    else if (stb.shiftIn)       sh <= shNext;
    else if (wrShift && !busy)  sh <= regWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sdo <= 1'b1;
    else if (stb.driveOut) sdo <= msbFirst ? sh[7] : sh[0];
  end

  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.driveOut |=> $stable(sdo));
endmodule

// File: rtl/burst_shift_port.sv
module burst_shift_port
  import bsp_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int DIV_W     = 8,
  localparam int PTR_W    = $clog2(BUF_BYTES),
  localparam int LEN_W    = $clog2(BUF_BYTES * 8),
  localparam int ADDR_W   = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              sdi,
  output logic              sdo,
  output logic              irq
);
  bspStb_t          stb;
  logic [PTR_W-1:0] ptr;
  logic [2:0]       partTop;
  logic             busy, clkEn, master, msbFirst, fallStb, riseStb;
  logic [DIV_W-1:0] divRd;
  logic [LEN_W-1:0] lenRd;
  logic [7:0]       ctrlRd, shRd, bufRd;
  logic             isBuf, isReg;

  assign isBuf = regAddr[ADDR_W-1];
  assign isReg = !regAddr[ADDR_W-1] && (regAddr[PTR_W-1:2] == '0);
  assign sckOe = master;

  bsp_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rstN(rstN), .en(clkEn), .master(master), .div(divRd),
    .sckIn(sckIn), .sckOut(sckOut), .fallStb(fallStb), .riseStb(riseStb)
  );

  bsp_ctrl #(.BUF_BYTES(BUF_BYTES), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrCtrl(regWe && isReg && regAddr[1:0] == SEL_CTRL),
    .wrBaud(regWe && isReg && regAddr[1:0] == SEL_BAUD),
    .wrLen (regWe && isReg && regAddr[1:0] == SEL_LEN),
    .regWdata(regWdata), .fallStb(fallStb), .riseStb(riseStb),
    .stb(stb), .ptr(ptr), .partTop(partTop), .busy(busy), .clkEn(clkEn),
    .master(master), .msbFirst(msbFirst), .divRd(divRd), .lenRd(lenRd),
    .ctrlRd(ctrlRd), .irq(irq)
  );

  bsp_datapath #(.BUF_BYTES(BUF_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ptr(ptr), .partTop(partTop),
    .msbFirst(msbFirst), .busy(busy), .sdi(sdi),
    .wrShift(regWe && isReg && regAddr[1:0] == SEL_SHIFT),
    .wrBuf(regWe && isBuf), .bufIdx(regAddr[PTR_W-1:0]),
    .regWdata(regWdata), .sdo(sdo), .shRd(shRd), .bufRd(bufRd)
  );

  always_comb begin
    regRdata = '0;
    if (isBuf) regRdata = bufRd;
    else if (isReg) begin
      case (regAddr[1:0])
        SEL_CTRL: regRdata = ctrlRd;
        SEL_BAUD: regRdata = 8'(divRd);
        SEL_LEN:  regRdata = 8'(lenRd);
        default:  regRdata = shRd;
      endcase
    end
  end
endmodule

// File: tb/burst_shift_port_tb_top.sv
module burst_shift_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [5:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic       sckIn = 1'b1;
  logic       sdi = 1'b1;
  wire  [7:0] regRdata;
  wire        sckOut, sckOe, sdo, irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  burst_shift_port dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sckIn(sckIn),
    .sckOut(sckOut), .sckOe(sckOe), .sdi(sdi), .sdo(sdo), .irq(irq)
  );

  wire sckLine = sckOe ? sckOut : sckIn;

  bit         rxPat [256];
  bit         txCap [256];
  logic [7:0] bufInit [32];
  int sdiIdx = 0, txIdx = 0, irqCnt = 0, cyc = 0, fallC0 = 0, fallC1 = 0;

  always @(posedge clk) begin
    cyc++;
    if (irq) irqCnt++;
  end

  // remote side: new data after each falling edge, capture on rising edge
  always @(negedge sckLine) begin
    if (sdiIdx == 0) fallC0 = cyc;
    if (sdiIdx == 1) fallC1 = cyc;
    if (sdiIdx < 256) sdi = rxPat[sdiIdx];
    sdiIdx++;
  end
  always @(posedge sckLine) begin
    if (txIdx < 256) txCap[txIdx] = sdo;
    txIdx++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 6'(a); regWdata = 8'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    regAddr = 6'(a);
    #1ns;
    v = regRdata;
  endtask

  function automatic logic [7:0] expRx(input int j, input int len, input int msb);
    int k = (len - 8 * j) < 8 ? (len - 8 * j) : 8;
    logic [7:0] v = '0;
    for (int m = 0; m < k; m++)
      if (rxPat[8 * j + m]) v[msb ? (k - 1 - m) : m] = 1'b1;
    return v;
  endfunction

  task automatic fillPatterns(input int seed);
    for (int j = 0; j < 32; j++) begin
      bufInit[j] = 8'((j * 29 + seed * 7) ^ 8'h5A);
      wr(32 + j, bufInit[j]);
    end
    for (int i = 0; i < 256; i++) rxPat[i] = ((i * 5 + seed * 3) % 7) < 3;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    int n = 0;
    rd(0, v);
    while (v[0] && n < 30000) begin rd(0, v); n++; end
    chk(v[0] == 1'b0, "R9", "run bit clears", v[0], 0);
    chk(v[5] == 1'b1, "R9", "done bit", v[5], 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkBuffer(input int len, input int msb, input int nb, input string tag);
    logic [7:0] v, e;
    int bad = 0, badP = 0, badU = 0;
    for (int j = 0; j < 32; j++) begin
      rd(32 + j, v);
      if (j < nb) begin
        e = expRx(j, len, msb);
        if (v !== e) begin
          if ((len % 8) != 0 && j == nb - 1) badP++; else bad++;
        end
      end else if (v !== bufInit[j]) badU++;
    end
    chk(bad == 0, tag, "received bytes in buffer mismatches", bad, 0);
    if ((len % 8) != 0 && nb > 0)
      chk(badP == 0, "R7", "right-aligned partial byte", badP, 0);
    chk(badU == 0, "R12", "untouched buffer bytes", badU, 0);
  endtask

  task automatic runXfer(input int master, input int msb, input int cont,
                         input int len, input int div);
    logic [7:0] v, single;
    int bad = 0;
    fillPatterns(len + div * 3 + msb * 11 + master);
    single = 8'(len * 37 + msb * 90 + div * 5 + 3);
    if (!cont) wr(3, single);
    wr(1, div);
    wr(2, len - 1);
    sdiIdx = 0; txIdx = 0; irqCnt = 0;
    wr(0, 1 | (master << 1) | (msb << 2) | (cont << 3));
    chk(sckOe == 1'(master), "R10", "clock drive enable", sckOe, master);
    if (!master) begin
      for (int i = 0; i < len; i++) begin
        repeat (6) @(negedge clk); sckIn = 1'b0;
        repeat (6) @(negedge clk); sckIn = 1'b1;
      end
    end
    waitIdle();
    chk(irqCnt == 1, "R9", "interrupt pulse cycles", irqCnt, 1);
    chk(txIdx == len, cont ? "R6" : "R5", "bits clocked", txIdx, len);
    for (int i = 0; i < len; i++) begin
      logic [7:0] src = cont ? bufInit[i / 8] : single;
      if (txCap[i] != src[msb ? 7 - (i % 8) : (i % 8)]) bad++;
    end
    chk(bad == 0, msb ? "R4" : "R3", "sent bit stream mismatches", bad, 0);
    if (master && len >= 2)
      chk(fallC1 - fallC0 == 2 * (div + 1), "R2", "clock period",
          fallC1 - fallC0, 2 * (div + 1));
    if (!cont) begin
      rd(3, v);
      chk(v == expRx(0, 8, msb), "R5", "single byte received", v, expRx(0, 8, msb));
    end
    checkBuffer(len, msb, cont ? (len + 7) / 8 : 0, "R6");
  endtask

  task automatic holdTest();
    logic [7:0] v;
    int n = 0, bad = 0;
    fillPatterns(77);
    wr(1, 1);
    wr(2, 23);
    sdiIdx = 0; txIdx = 0; irqCnt = 0;
    wr(0, 8'h1B);
    while (txIdx < 8 && n < 3000) begin @(negedge clk); n++; end
    repeat (40) @(negedge clk);
    chk(txIdx == 8, "R8", "bits before hold", txIdx, 8);
    chk(sckOut == 1'b1, "R8", "clock high in hold", sckOut, 1);
    rd(0, v);
    chk(v[0] == 1'b1, "R8", "still busy in hold", v[0], 1);
    rd(32, v);
    chk(v == expRx(0, 24, 0), "R8", "first byte stored at hold", v, expRx(0, 24, 0));
    wr(2, 3); wr(1, 9); wr(37, 8'h00); wr(3, 8'hAA);
    rd(2, v);  chk(v == 8'd23, "R11", "length write ignored", v, 23);
    rd(1, v);  chk(v == 8'd1, "R11", "divider write ignored", v, 1);
    rd(37, v); chk(v == bufInit[5], "R11", "buffer write ignored", v, bufInit[5]);
    wr(0, 8'h00);
    rd(0, v);
    chk(v[1] == 1'b1 && v[3] == 1'b1, "R11", "mode bits kept while busy", v, 8'h0B);
    waitIdle();
    chk(txIdx == 24, "R8", "bits after resume", txIdx, 24);
    chk(irqCnt == 1, "R9", "interrupt after resume", irqCnt, 1);
    for (int i = 0; i < 24; i++)
      if (txCap[i] != bufInit[i / 8][i % 8]) bad++;
    chk(bad == 0, "R8", "stream across hold", bad, 0);
    checkBuffer(24, 0, 3, "R8");
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(sckOut == 1'b1, "R1", "clock idle", sckOut, 1);
    chk(sdo == 1'b1, "R1", "data out idle", sdo, 1);
    chk(irq == 1'b0, "R1", "irq idle", irq, 0);
    chk(sckOe == 1'b0, "R1", "clock enable idle", sckOe, 0);
    rd(0, v);
    chk(v == 8'h00, "R1", "control reset value", v, 0);

    for (int msb = 0; msb < 2; msb++)
      for (int m = 0; m < 2; m++)
        for (int d = 0; d < 4; d += 3) runXfer(m, msb, 0, 8, d);
    for (int msb = 0; msb < 2; msb++) begin
      for (int len = 1; len <= 40; len++) runXfer(1, msb, 1, len, 0);
      for (int len = 249; len <= 256; len++) runXfer(1, msb, 1, len, 0);
    end
    for (int d = 0; d < 8; d++) runXfer(1, d % 2, 1, 16, d);
    for (int msb = 0; msb < 2; msb++)
      foreach (rxPat[i]) if (i < 7) runXfer(0, msb, 1, (i * 8 + 1) % 18 + 1, 0);
    holdTest();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 199000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule